// File: doc/BRIEF.md
# Scan Test Sequencer with At-Speed Delay Modes

This block drives one internal scan chain of configurable length during manufacturing test. It takes stimulus words one at a time from a valid/ready input and shifts each one serially into the chain. It then steps the chain through its capture cycles and assembles the response that comes back out of the chain into a parallel word. The chain itself, the clock generator and the pattern source sit outside the block. Towards the chain the block drives a scan-enable, a serial scan-in bit and a clock enable. A one-bit clock-select output tells the clock generator whether a cycle must run at functional (at-speed) rate.

Three disciplines are supported. The first is a plain static capture for stuck-at testing. The second is a double-capture discipline, where two functional clock pulses launch and capture a transition after a slow load. The third is a skewed-load discipline, where the final shift pulse is the launch and an at-speed capture follows at once. The response of one pattern leaves the chain while the next pattern enters it. After the last pattern, a zero-filled flush pushes the final response out, and a one-cycle completion pulse follows.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, scan_en_o, scan_clk_en_o, at_speed_o, pat_ready_o, resp_valid_o, done_o and busy_o are all 0.
- R2: In static mode (mode_i = 0), each pattern gets exactly CHAIN_LEN clocked shift cycles with scan_en_o = 1. These are followed by exactly one capture cycle with scan_en_o = 0 and scan_clk_en_o = 1.
- R3: Bit CHAIN_LEN-1 of a pattern word is driven on scan_si_o first and bit 0 last. The chain shifts from scan_si_o into position 0 towards position CHAIN_LEN-1, which drives scan_so_i. So, at capture, chain position i holds pattern bit i.
- R4: The unload of response k overlaps the load of pattern k+1. With a valid pattern always available, a static run of P patterns keeps busy_o high for P*(CHAIN_LEN+1)+CHAIN_LEN cycles (27 for CHAIN_LEN=6, P=3). Each stall cycle adds one cycle.
- R5: For each pattern, in order, resp_valid_o pulses for one cycle. Bit i of resp_data_o then equals the content of chain position i after the last capture of that pattern.
- R6: After the last pattern's capture, exactly CHAIN_LEN clocked shift cycles follow, with scan_si_o = 0 in each.
- R7: In double-capture mode (mode_i = 1), the CHAIN_LEN slow shifts of each pattern are followed by exactly two cycles with scan_en_o = 0, scan_clk_en_o = 1 and at_speed_o = 1. Each pattern therefore takes CHAIN_LEN+2 cycles.
- R8: In skewed-load mode (mode_i = 2), CHAIN_LEN-1 slow shifts are followed by one shift with at_speed_o = 1. One capture with at_speed_o = 1 comes straight after.
- R9: at_speed_o is 1 only in the launch and capture cycles of R7 and R8, and it always comes with scan_clk_en_o = 1. In static mode it stays 0.
- R10: pat_ready_o is 1 only in the cycle that needs the first bit of a new pattern. If pat_valid_i is 0 there, the block stalls: scan_en_o stays 1 and scan_clk_en_o is 0.
- R11: done_o is a one-cycle pulse. It comes in the cycle after the last flush shift, together with the final resp_valid_o, and busy_o is 0 in that cycle.
- R12: mode_i = 3 behaves as static mode. While busy_o is 1, start_i and mode_i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run when idle |
| mode_i | input | 2 | 0 static, 1 double capture, 2 skewed load, 3 static |
| pat_valid_i | input | 1 | Stimulus word available |
| pat_ready_o | output | 1 | Stimulus word taken when valid |
| pat_data_i | input | CHAIN_LEN | Stimulus word |
| pat_last_i | input | 1 | Marks the final stimulus word |
| scan_so_i | input | 1 | Serial output of the chain |
| scan_en_o | output | 1 | Shift (1) or capture (0) select for the chain |
| scan_si_o | output | 1 | Serial input to the chain |
| scan_clk_en_o | output | 1 | Chain clock enable |
| at_speed_o | output | 1 | Request for a functional-rate clock pulse |
| resp_valid_o | output | 1 | Response word strobe |
| resp_data_o | output | CHAIN_LEN | Response word |
| done_o | output | 1 | Run complete pulse |
| busy_o | output | 1 | Run in progress |

## Verification
The assertions assume that the chain moves only when scan_clk_en_o is 1. They also assume that the pattern source holds its word steady within a cycle and marks exactly one word as the last. The bench meets these assumptions with a cycle-level chain model clocked by the enable. Its source raises valid at random stall rates and always marks the P-th word as the last. Directed runs cover the 27-cycle case, a single-pattern run, the reserved mode code, and start and mode changes issued mid-run.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LAUNCH,
        ST_CAPT,
        ST_FLUSH
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_STUCK     = 2'd0,
        MODE_BROADSIDE = 2'd1,
        MODE_SKEWED    = 2'd2,
        MODE_RSVD      = 2'd3
    } seq_mode_e;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       pat_valid_i,
    input  logic       pat_last_i,
    output logic       pat_ready_o,
    output logic       load_o,
    output logic       adv_o,
    output logic       flush_o,
    output logic       collect_o,
    output logic       resp_end_o,
    output logic       scan_en_o,
    output logic       scan_clk_en_o,
    output logic       at_speed_o,
    output logic       done_o,
    output logic       busy_o
);
    localparam int CW = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(CHAIN_LEN - 1);

    typedef struct packed {
        seq_state_e    state;
        seq_mode_e     mode;
        logic [CW-1:0] cnt;
        logic          last;
        logic          have_resp;
        logic          done;
    } ctrl_reg_t;

    ctrl_reg_t r_q, r_d;

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        pat_ready_o   = 1'b0;
        load_o        = 1'b0;
        adv_o         = 1'b0;
        flush_o       = 1'b0;
        collect_o     = 1'b0;
        resp_end_o    = 1'b0;
        scan_en_o     = 1'b0;
        scan_clk_en_o = 1'b0;
        at_speed_o    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state     = ST_SHIFT;
                    r_d.cnt       = '0;
                    r_d.last      = 1'b0;
                    r_d.have_resp = 1'b0;
                    r_d.mode      = (mode_i == MODE_RSVD) ? MODE_STUCK : seq_mode_e'(mode_i);
                end
            end
            ST_SHIFT: begin
                scan_en_o = 1'b1;
                if (r_q.cnt == '0) begin
                    pat_ready_o = 1'b1;
                    load_o      = pat_valid_i;
                    if (pat_valid_i) begin
                        r_d.last = pat_last_i;
                    end
                end else begin
                    adv_o = 1'b1;
                end
                if (load_o || adv_o) begin
                    scan_clk_en_o = 1'b1;
                    collect_o     = r_q.have_resp;
                    if (r_q.cnt == LAST_IDX) begin
                        resp_end_o = r_q.have_resp;
                        at_speed_o = (r_q.mode == MODE_SKEWED);
                        r_d.cnt    = '0;
                        r_d.state  = (r_q.mode == MODE_BROADSIDE) ? ST_LAUNCH : ST_CAPT;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_LAUNCH: begin
                scan_clk_en_o = 1'b1;
                at_speed_o    = 1'b1;
                r_d.state     = ST_CAPT;
            end
            ST_CAPT: begin
                scan_clk_en_o = 1'b1;
                at_speed_o    = (r_q.mode != MODE_STUCK);
                r_d.have_resp = 1'b1;
                r_d.cnt       = '0;
                r_d.state     = r_q.last ? ST_FLUSH : ST_SHIFT;
            end
            ST_FLUSH: begin
                scan_en_o     = 1'b1;
                scan_clk_en_o = 1'b1;
                flush_o       = 1'b1;
                adv_o         = 1'b1;
                collect_o     = 1'b1;
                if (r_q.cnt == LAST_IDX) begin
                    resp_end_o = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                    r_d.cnt    = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, mode: MODE_STUCK, cnt: '0,
                     last: 1'b0, have_resp: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
    assign busy_o = (r_q.state != ST_IDLE);

    // R2: a static capture is always followed by a shifting cycle
    p_stuck_single_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_CAPT && r_q.mode == MODE_STUCK) |=> scan_en_o)
        else $error("p_stuck_single_cap_r2");

    // R7: the launch pulse is followed by an at-speed capture
    p_broadside_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_LAUNCH) |=> (r_q.state == ST_CAPT && at_speed_o && !scan_en_o))
        else $error("p_broadside_pair_r7");

    // R8: a fast shift only happens as the last shift of a skewed load
    p_skew_fast_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (at_speed_o && scan_en_o) |-> (r_q.mode == MODE_SKEWED && r_q.cnt == LAST_IDX))
        else $error("p_skew_fast_shift_r8");

    // R8: the fast shift is followed by a capture with no enable gap
    p_skew_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (at_speed_o && scan_en_o) |=> (!scan_en_o && scan_clk_en_o && at_speed_o))
        else $error("p_skew_capture_r8");

    // R9: a fast pulse request always comes with a clocked chain
    p_fast_clocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        at_speed_o |-> scan_clk_en_o)
        else $error("p_fast_clocked_r9");

    // R10: a stall freezes the chain while holding shift mode
    p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pat_ready_o && !pat_valid_i) |-> (scan_en_o && !scan_clk_en_o))
        else $error("p_stall_hold_r10");

endmodule

// File: rtl/scan_seq_stim.sv
module scan_seq_stim #(
    parameter int CHAIN_LEN = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [CHAIN_LEN-1:0] pat_data_i,
    input  logic                 load_i,
    input  logic                 adv_i,
    input  logic                 flush_i,
    output logic                 scan_si_o
);
    logic [CHAIN_LEN-1:0] shreg_q, shreg_d;

    always_comb begin
        shreg_d = shreg_q;
        if (load_i) begin
            shreg_d = {pat_data_i[CHAIN_LEN-2:0], 1'b0};
        end else if (adv_i) begin
            shreg_d = {shreg_q[CHAIN_LEN-2:0], 1'b0};
        end
        if (flush_i) begin
            scan_si_o = 1'b0;
        end else if (load_i) begin
            scan_si_o = pat_data_i[CHAIN_LEN-1];
        end else begin
            scan_si_o = shreg_q[CHAIN_LEN-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shreg_q <= '0;
        end else begin
            shreg_q <= shreg_d;
        end
    end

endmodule

// File: rtl/scan_seq_resp.sv
module scan_seq_resp #(
    parameter int CHAIN_LEN = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 scan_so_i,
    input  logic                 collect_i,
    input  logic                 resp_end_i,
    output logic                 resp_valid_o,
    output logic [CHAIN_LEN-1:0] resp_data_o
);
    logic [CHAIN_LEN-2:0] col_q, col_d;
    logic [CHAIN_LEN-1:0] data_q, data_d;
    logic                 valid_q, valid_d;
    logic [CHAIN_LEN-1:0] wide;

    always_comb begin
        wide    = {col_q, scan_so_i};
        col_d   = collect_i ? wide[CHAIN_LEN-2:0] : col_q;
        data_d  = resp_end_i ? wide : data_q;
        valid_d = resp_end_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            col_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            col_q   <= col_d;
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign resp_valid_o = valid_q;
    assign resp_data_o  = data_q;

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
    parameter int CHAIN_LEN = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [1:0]           mode_i,
    input  logic                 pat_valid_i,
    output logic                 pat_ready_o,
    input  logic [CHAIN_LEN-1:0] pat_data_i,
    input  logic                 pat_last_i,
    input  logic                 scan_so_i,
    output logic                 scan_en_o,
    output logic                 scan_si_o,
    output logic                 scan_clk_en_o,
    output logic                 at_speed_o,
    output logic                 resp_valid_o,
    output logic [CHAIN_LEN-1:0] resp_data_o,
    output logic                 done_o,
    output logic                 busy_o
);
    logic load_w, adv_w, flush_w, collect_w, resp_end_w;

    scan_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_i       (start_i),
        .mode_i        (mode_i),
        .pat_valid_i   (pat_valid_i),
        .pat_last_i    (pat_last_i),
        .pat_ready_o   (pat_ready_o),
        .load_o        (load_w),
        .adv_o         (adv_w),
        .flush_o       (flush_w),
        .collect_o     (collect_w),
        .resp_end_o    (resp_end_w),
        .scan_en_o     (scan_en_o),
        .scan_clk_en_o (scan_clk_en_o),
        .at_speed_o    (at_speed_o),
        .done_o        (done_o),
        .busy_o        (busy_o)
    );

    scan_seq_stim #(.CHAIN_LEN(CHAIN_LEN)) u_stim (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pat_data_i (pat_data_i),
        .load_i     (load_w),
        .adv_i      (adv_w),
        .flush_i    (flush_w),
        .scan_si_o  (scan_si_o)
    );

    scan_seq_resp #(.CHAIN_LEN(CHAIN_LEN)) u_resp (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .scan_so_i    (scan_so_i),
        .collect_i    (collect_w),
        .resp_end_i   (resp_end_w),
        .resp_valid_o (resp_valid_o),
        .resp_data_o  (resp_data_o)
    );

    // R6: flush shifts feed zeros
    p_flush_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_w |-> (!scan_si_o && scan_en_o))
        else $error("p_flush_zero_r6");

    // R11: completion coincides with the final response word
    p_done_with_resp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (resp_valid_o && !busy_o))
        else $error("p_done_with_resp_r11");

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o)
        else $error("p_done_pulse_r11");

    // R5: response strobes are single-cycle
    p_resp_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_valid_o |=> !resp_valid_o)
        else $error("p_resp_pulse_r5");

endmodule

// File: tb/scan_test_seq_tb.sv
`timescale 1ns/1ps
module scan_test_seq_tb;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode_sel = 2'd0;
    logic         pat_valid = 1'b0;
    logic         pat_ready;
    logic [N-1:0] pat_data = '0;
    logic         pat_last = 1'b0;
    logic         scan_so;
    logic         scan_en, scan_si, scan_ce, at_speed;
    logic         resp_valid, done, busy;
    logic [N-1:0] resp_data;
    logic [N-1:0] chain = '0;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    scan_test_seq #(.CHAIN_LEN(N)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode_sel),
        .pat_valid_i(pat_valid), .pat_ready_o(pat_ready), .pat_data_i(pat_data),
        .pat_last_i(pat_last), .scan_so_i(scan_so), .scan_en_o(scan_en),
        .scan_si_o(scan_si), .scan_clk_en_o(scan_ce), .at_speed_o(at_speed),
        .resp_valid_o(resp_valid), .resp_data_o(resp_data), .done_o(done),
        .busy_o(busy)
    );

    // chain model: position 0 takes scan-in, position N-1 drives scan-out
    function automatic logic [N-1:0] logic_fn(input logic [N-1:0] x);
        return {x[N-2:0], x[N-1]} ^ (x & 6'h2A) ^ 6'h13;
    endfunction

    function automatic logic [N-1:0] expect_resp(input logic [N-1:0] p, input logic [1:0] md);
        return (md == 2'd1) ? logic_fn(logic_fn(p)) : logic_fn(p);
    endfunction

    assign scan_so = chain[N-1];
    always @(posedge clk) begin
        if (scan_ce) begin
            if (scan_en) chain <= {chain[N-2:0], scan_si};
            else         chain <= logic_fn(chain);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] md, input int np, input int stall_pct, input bit inj);
        logic [N-1:0] pats [8];
        bit bcast = (md == 2'd1);
        bit skew  = (md == 2'd2);
        bit fast_mode = bcast || skew;
        int idx = 0, acc = 0, cyc = 0, stalls = 0, nresp = 0, lowrun = 0;
        int shifts = 0, caps = 0, fast = 0, fastshift = 0, flushcyc = 0, iter = 0;
        int bad_stall = 0, bad_low = 0, bad_skew = 0, bad_flush = 0, bad_resp = 0;
        bit fin = 0;
        for (int j = 0; j < 8; j++) pats[j] = N'($urandom);
        @(negedge clk);
        start = 1'b1;
        mode_sel = md;
        pat_valid = 1'b0;
        while (!fin && iter < 2000) begin
            @(negedge clk);
            iter++;
            idx += acc;
            acc = 0;
            start = 1'b0;
            mode_sel = md;
            if (inj && iter == 5) begin
                start = 1'b1;
                mode_sel = md ^ 2'b01;
            end
            pat_valid = (idx < np) && (int'($urandom % 100) >= stall_pct);
            pat_data  = pats[idx % 8];
            pat_last  = (idx == np - 1);
            #1;
            if (busy) cyc++;
            if (busy && pat_ready && !pat_valid) begin
                stalls++;
                if (!(scan_en && !scan_ce)) bad_stall++;
            end
            if (pat_ready && pat_valid) acc = 1;
            if (at_speed) fast++;
            if (busy) begin
                if (!scan_en) begin
                    if (lowrun == 0) begin
                        if (shifts != N) bad_low++;
                        if (caps == 0) chk("R3 chain holds first pattern", int'(chain), int'(pats[0]));
                    end
                    lowrun++;
                    if (!scan_ce || (at_speed != fast_mode)) bad_low++;
                end else begin
                    if (lowrun > 0) begin
                        if (lowrun != (bcast ? 2 : 1)) bad_low++;
                        caps++;
                        lowrun = 0;
                        shifts = 0;
                    end
                    if (scan_ce) begin
                        if (at_speed) begin
                            fastshift++;
                            if (!skew || shifts != N - 1) bad_skew++;
                        end
                        shifts++;
                        if (caps == np) begin
                            flushcyc++;
                            if (scan_si) bad_flush++;
                        end
                    end
                end
            end
            if (resp_valid) begin
                if (nresp < np && resp_data != expect_resp(pats[nresp], md)) begin
                    bad_resp++;
                    $display("FAIL R5 response %0d actual=%0h expected=%0h",
                             nresp, resp_data, expect_resp(pats[nresp], md));
                end
                nresp++;
            end
            if (done) begin
                chk("R11 done with final response", int'(resp_valid), 1);
                chk("R11 busy low at done", int'(busy), 0);
                fin = 1;
            end
        end
        chk("watchdog run completed", int'(fin), 1);
        @(negedge clk);
        #1;
        chk("R11 done is one pulse", int'(done), 0);
        chk("R5 response count", nresp, np);
        chk("R5 response values", bad_resp, 0);
        chk("R4 R7 busy cycle count", cyc, np * (N + 1 + int'(bcast)) + N + stalls);
        chk("R2 R7 capture run shape", bad_low, 0);
        chk("R2 captures per pattern", caps, np);
        chk("R9 at-speed cycle count", fast, fast_mode ? 2 * np : 0);
        chk("R8 fast last shift count", fastshift, skew ? np : 0);
        chk("R8 fast shift position", bad_skew, 0);
        chk("R6 flush length", flushcyc, N);
        chk("R6 flush zero fill", bad_flush, 0);
        chk("R10 stall holds shift", bad_stall, 0);
        pat_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = int'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 scan_en after reset", int'(scan_en), 0);
        chk("R1 clock enable after reset", int'(scan_ce), 0);
        chk("R1 at_speed after reset", int'(at_speed), 0);
        chk("R1 ready/valid/done/busy after reset",
            int'({pat_ready, resp_valid, done, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: directed 6-bit chain, 3 patterns, no stall: 27 cycles
        run(2'd0, 3, 0, 1'b0);
        // R7: double capture with stalls
        run(2'd1, 4, 30, 1'b0);
        // R8: skewed load with stalls
        run(2'd2, 4, 30, 1'b0);
        // R12: reserved code behaves as static
        run(2'd3, 2, 0, 1'b0);
        // R12: start and mode pulses mid-run are ignored
        run(2'd0, 3, 10, 1'b1);
        run(2'd2, 3, 0, 1'b1);
        // single pattern corner
        run(2'd1, 1, 0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            run(2'($urandom % 4), 1 + int'($urandom % 6), int'($urandom % 50), 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule